// File: doc/BRIEF.md
# Shared Analog-Pin Digital Input Port

This block lets eight pins that double as analog converter inputs also serve as plain digital inputs. A per-channel enable register decides which pins drive their digital level into a read-only port value. A pin whose enable is clear reads back as 1, except when that channel is the one picked as the external trigger source for the converter. A pin picked that way is always readable, so firmware can see the trigger line without enabling its input buffer.

Software reaches the block over a small synchronous register bus with an address, a write strobe, a read strobe and 8-bit data. One address holds the enable register. A second address returns the port value, and writes to it are dropped. Any other address reads 0. Pin levels pass through a two-stage synchronizer on the bus clock before they reach the read path. The trigger settings come in as static configuration inputs from the converter's control logic.

Top module: `ana_din_port`

## Requirements
- R1: A write at address 0x0 loads the enable register, where bit n enables channel n; a read at address 0x0 returns the stored value, at any time.
- R2: After reset the enable register is 0x00, a read of address 0x1 returns 0xFF, and rdata_o is 0x00.
- R3: For a channel whose enable bit is 1, the port value bit at address 0x1 equals the level of that pin.
- R4: When trig_en_i is 1, trig_src_i is 0 and trig_ch_i equals x, bit x of the port value follows pin x even when enable bit x is 0.
- R5: When trig_en_i is 0 or trig_src_i is 1, trig_ch_i has no effect on the port value.
- R6: A channel whose enable bit is 0 and which is not the selected trigger channel reads as 1, whatever its pin level.
- R7: A write to address 0x1 changes neither the enable register nor the port value.
- R8: A read of any address other than 0x0 and 0x1 returns 0x00, and a write to such an address leaves the enable register unchanged.
- R9: rdata_o is registered: it takes the addressed value at the clock edge where rd_i is 1 and holds its value in cycles where rd_i is 0.
- R10: A pin change first shows in a read whose rd_i edge is the third rising clock edge after the change; a read at the first edge after the change still returns the old level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| pin_i | input | 8 | Raw pin levels, bit n is channel n |
| trig_en_i | input | 1 | External trigger enable |
| trig_ch_i | input | 3 | External trigger channel number |
| trig_src_i | input | 1 | Trigger source select; 0 means a pin of this port |

## Verification
A register write takes effect at the edge where wr_i is high, so a read strobe issued in the next cycle already sees it. Read data lands in rdata_o at the edge where rd_i is high, and the bench samples it at the following falling edge. A pin change made at a falling edge reaches the second synchronizer stage two rising edges later, so the bench waits two idle cycles before it reads the new level. It also reads straight after a change, at the first edge, to confirm that the old level is still returned. Pins and trigger inputs are only ever changed at falling edges.

// File: rtl/adp_pkg.sv
package adp_pkg;
  localparam int unsigned N_CH   = 8;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned CH_W   = $clog2(N_CH);

  localparam logic [ADDR_W-1:0] ADDR_EN   = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_PORT = 4'h1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_EN   = 2'd1,
    SEL_PORT = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/adp_sync.sv
module adp_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/adp_en_reg.sv
module adp_en_reg
  import adp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  reg_sel_e        sel_i,
  input  logic            wr_i,
  input  logic [N_CH-1:0] wdata_i,
  output logic [N_CH-1:0] en_o
);
  logic [N_CH-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     en_q <= '0;
    else if (wr_i && sel_i == SEL_EN) en_q <= wdata_i;
  end

  assign en_o = en_q;

  a_r1_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_EN) |=> en_q == $past(wdata_i));
  a_r7_port_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_PORT) |=> $stable(en_q));
  a_r8_other_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_NONE) |=> $stable(en_q));
endmodule

// File: rtl/adp_port_view.sv
module adp_port_view
  import adp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] en_i,
  input  logic [N_CH-1:0] sync_i,
  input  logic            trig_en_i,
  input  logic [CH_W-1:0] trig_ch_i,
  input  logic            trig_src_i,
  output logic [N_CH-1:0] port_o
);
  logic trig_pin;
  assign trig_pin = trig_en_i && !trig_src_i;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic hit;
    assign hit       = trig_pin && (trig_ch_i == CH_W'(c));
    assign port_o[c] = (en_i[c] || hit) ? sync_i[c] : 1'b1;
  end

  a_r6_disabled_reads_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0 && !trig_pin) |-> port_o == '1);
  a_r4_single_trig_channel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> $countones(~port_o) <= 1);
  a_r3_enabled_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_i & sync_i) == '0 && en_i != '0) |-> (port_o & en_i) == '0);
endmodule

// File: rtl/adp_rd_mux.sv
module adp_rd_mux
  import adp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  reg_sel_e        sel_i,
  input  logic            rd_i,
  input  logic [N_CH-1:0] en_i,
  input  logic [N_CH-1:0] port_i,
  output logic [N_CH-1:0] rdata_o
);
  logic [N_CH-1:0] rdata_q;
  logic [N_CH-1:0] rd_val;

  always_comb begin
    unique case (sel_i)
      SEL_EN:   rd_val = en_i;
      SEL_PORT: rd_val = port_i;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  a_r8_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_i == SEL_NONE) |=> rdata_o == '0);
  a_r1_en_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_i == SEL_EN) |=> rdata_o == $past(en_i));
endmodule

// File: rtl/ana_din_port.sv
module ana_din_port
  import adp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [N_CH-1:0]   wdata_i,
  output logic [N_CH-1:0]   rdata_o,
  input  logic [N_CH-1:0]   pin_i,
  input  logic              trig_en_i,
  input  logic [CH_W-1:0]   trig_ch_i,
  input  logic              trig_src_i
);
  reg_sel_e        sel;
  logic [N_CH-1:0] en;
  logic [N_CH-1:0] pin_sync;
  logic [N_CH-1:0] port_val;

  always_comb begin
    if (addr_i == ADDR_EN)        sel = SEL_EN;
    else if (addr_i == ADDR_PORT) sel = SEL_PORT;
    else                          sel = SEL_NONE;
  end

  adp_sync #(.WIDTH(N_CH), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  adp_en_reg u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .wr_i   (wr_i),
    .wdata_i(wdata_i),
    .en_o   (en)
  );

  adp_port_view u_view (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .sync_i    (pin_sync),
    .trig_en_i (trig_en_i),
    .trig_ch_i (trig_ch_i),
    .trig_src_i(trig_src_i),
    .port_o    (port_val)
  );

  adp_rd_mux u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .rd_i   (rd_i),
    .en_i   (en),
    .port_i (port_val),
    .rdata_o(rdata_o)
  );

  a_r5_trig_off_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_en_i || trig_src_i) && en == '0 |-> port_val == '1);
endmodule

// File: tb/ana_din_port_test.sv
module ana_din_port_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [7:0] pin_i = '0;
  logic       trig_en_i = 1'b0;
  logic [2:0] trig_ch_i = '0;
  logic       trig_src_i = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  ana_din_port uut (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  // pins changed at a negedge need two edges before the read edge
  task automatic set_pins(logic [7:0] p);
    @(negedge clk_i);
    pin_i = p;
    idle(2);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R2 rdata after reset", rdata_o, 8'h00);
    rd(4'h0, d); chk("R2 enable reset", d, 8'h00);
    rd(4'h1, d); chk("R2 port reset", d, 8'hFF);
  endtask

  task automatic t_enable_rw();
    logic [7:0] d;
    wr(4'h0, 8'hA5); rd(4'h0, d); chk("R1 enable readback A5", d, 8'hA5);
    wr(4'h0, 8'h3C); rd(4'h0, d); chk("R1 enable readback 3C", d, 8'h3C);
    wr(4'h0, 8'h00);
  endtask

  task automatic t_enabled();
    logic [7:0] d;
    wr(4'h0, 8'hFF);
    set_pins(8'h5A); rd(4'h1, d); chk("R3 all enabled 5A", d, 8'h5A);
    set_pins(8'h00); rd(4'h1, d); chk("R3 all enabled 00", d, 8'h00);
    wr(4'h0, 8'h0F);
    set_pins(8'h00); rd(4'h1, d); chk("R3 R6 low nibble enabled", d, 8'hF0);
    set_pins(8'h96); rd(4'h1, d); chk("R3 R6 low nibble 96", d, 8'hF6);
    wr(4'h0, 8'h00);
    set_pins(8'h00); rd(4'h1, d); chk("R6 all disabled pins low", d, 8'hFF);
  endtask

  task automatic t_trigger();
    logic [7:0] d;
    wr(4'h0, 8'h00);
    set_pins(8'h00);
    @(negedge clk_i); trig_en_i = 1'b1; trig_src_i = 1'b0; trig_ch_i = 3'd5;
    rd(4'h1, d); chk("R4 trig ch5 low", d, 8'hDF);
    @(negedge clk_i); trig_ch_i = 3'd0;
    rd(4'h1, d); chk("R4 trig ch0 low", d, 8'hFE);
    @(negedge clk_i); trig_ch_i = 3'd7;
    rd(4'h1, d); chk("R4 trig ch7 low", d, 8'h7F);
    @(negedge clk_i); trig_src_i = 1'b1;
    rd(4'h1, d); chk("R5 source select 1", d, 8'hFF);
    @(negedge clk_i); trig_src_i = 1'b0; trig_en_i = 1'b0;
    rd(4'h1, d); chk("R5 trigger disabled", d, 8'hFF);
    @(negedge clk_i); trig_ch_i = 3'd0;
  endtask

  task automatic t_port_write();
    logic [7:0] d;
    wr(4'h0, 8'hF0);
    set_pins(8'h00);
    wr(4'h1, 8'hFF);
    rd(4'h0, d); chk("R7 enable unchanged", d, 8'hF0);
    rd(4'h1, d); chk("R7 port unchanged", d, 8'h0F);
  endtask

  task automatic t_other_addr();
    logic [7:0] d;
    wr(4'h0, 8'h00);
    rd(4'h2, d); chk("R8 addr 2 reads 0", d, 8'h00);
    rd(4'hF, d); chk("R8 addr F reads 0", d, 8'h00);
    wr(4'h7, 8'hFF);
    rd(4'h0, d); chk("R8 enable after stray write", d, 8'h00);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    wr(4'h0, 8'h81);
    rd(4'h0, d);
    wr(4'h0, 8'h18);
    idle(2);
    chk("R9 rdata held without rd", rdata_o, 8'h81);
    rd(4'h0, d); chk("R9 next read updates", d, 8'h18);
  endtask

  task automatic t_sync();
    logic [7:0] d;
    wr(4'h0, 8'hFF);
    set_pins(8'h00);
    @(negedge clk_i);
    pin_i = 8'hFF; addr_i = 4'h1; rd_i = 1'b1;
    @(negedge clk_i); d = rdata_o; chk("R10 first edge old level", d, 8'h00);
    @(negedge clk_i); d = rdata_o; chk("R10 second edge old level", d, 8'h00);
    @(negedge clk_i); rd_i = 1'b0; d = rdata_o; chk("R10 third edge new level", d, 8'hFF);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    t_reset();
    t_enable_rw();
    t_enabled();
    t_trigger();
    t_port_write();
    t_other_addr();
    t_hold();
    t_sync();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule